// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block produces the interrupt conditions of a synchronous serial port. The receive and transmit FIFOs, the shift engine and the bit-rate prescaler all sit outside it and are seen only as signals: FIFO fill counts, a strobe for each completed received frame, a strobe for each receive FIFO read, and a one-cycle tick once per serial bit period. The bit period is the peripheral clock divided by prescale × (serial clock rate + 1), and it is the same in master and slave modes.

Four conditions are tracked:

- A latched receive overrun.
- A latched receive-idle timeout.
- A receive FIFO level flag.
- A transmit FIFO level flag.

Software reads them through a small word-wide register port. The port gives access to:

- an enable mask (read and write),
- the raw status (read-only),
- the masked status (read-only),
- a write-one-to-clear register for the two latched conditions.

A single interrupt line is the OR of the enabled conditions.

The FIFO depth is a parameter with a default of 8 entries, so the half-depth threshold defaults to 4. The timeout length is also a parameter, with a default of 32 bit periods.

Top module: `ssp_irq_status`

## Requirements
- R1: Status vector layout: bit 0 receive overrun, bit 1 receive timeout, bit 2 receive FIFO at least half full, bit 3 transmit FIFO at most half full. Bits 31:4 of every register read as 0.
- R2: After synchronous reset, the mask reads 0, both latched flags are 0 and `irq` is 0. With both FIFOs empty, the raw status reads 0x8.
- R3: The overrun flag sets at the clock edge where `rx_frame_done` is high while `rx_level` equals the FIFO depth. A completed frame at any lower level leaves it unchanged.
- R4: Timeout counting:
  - An idle counter counts `bit_tick` pulses while the receive FIFO is non-empty.
  - It restarts on `rx_pop` or `rx_frame_done`, and it is held at zero while `rx_level` is 0.
  - The timeout flag sets at the edge of the 32nd tick without a restart.
  - The counter then saturates, so the flag does not set again until a restart.
- R5: Bit 2 equals (`rx_level` ≥ depth/2) and bit 3 equals (`tx_level` ≤ depth/2), in the same cycle as the level inputs. Writes to the clear register have no effect on them.
- R6: Clear register (address 3):
  - Writing a 1 to bit 0 or bit 1 clears the matching latched flag at that edge.
  - A set event in the same cycle wins over the clear.
  - The register itself reads 0.
- R7: Masked status (address 2) equals raw status AND mask. `irq` is the OR of the four masked bits, and it is combinational from status and mask.
- R8: The mask (address 0) is read/write in bits 3:0. Writes to bits 31:4 are ignored and those bits read as 0.
- R9: Writes to the raw (address 1) and masked (address 2) addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| rx_frame_done | input | 1 | One-cycle strobe: a frame finished being received |
| rx_pop | input | 1 | One-cycle strobe: receive FIFO was read |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mask, 1 raw, 2 masked, 3 clear) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted latched flag is seen on the raw status read and, when enabled, on `irq` in the cycle right after the faulty edge. The bench compares every cycle, so such a fault is reported within one clock. An idle counter that is off by one shifts the rise of the timeout bit by one tick. This is caught by driving exactly 31 ticks, checking that the bit is still clear, then driving the 32nd. Level-flag threshold errors appear at once when occupancy is swept across the half-depth boundary in both directions.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;

    localparam int NUM_SRC = 4;

    typedef enum logic [1:0] {
        ADDR_MASK  = 2'd0,
        ADDR_RAW   = 2'd1,
        ADDR_MSTAT = 2'd2,
        ADDR_CLR   = 2'd3
    } reg_addr_e;

    // Bit 0 is the last member of the packed struct.
    typedef struct packed {
        logic tx_half_empty;
        logic rx_half_full;
        logic rx_idle;
        logic rx_overrun;
    } irq_vec_t;

    function automatic logic [31:0] widen(input irq_vec_t v);
        return {{(32-NUM_SRC){1'b0}}, v};
    endfunction

endpackage

// File: rtl/ssp_irq_latch.sv
module ssp_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst) set_i |=> flag_o);
    // R6
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ssp_irq_level.sv
module ssp_irq_level #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    output logic             rx_half_full,
    output logic             tx_half_empty
);
    localparam int HALF = DEPTH / 2;

    assign rx_half_full  = (rx_level >= CNT_W'(HALF));
    assign tx_half_empty = (tx_level <= CNT_W'(HALF));
endmodule

// File: rtl/ssp_irq_timeout.sv
module ssp_irq_timeout #(
    parameter int DEPTH   = 8,
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter int TO_BITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             rx_pop,
    input  logic             rx_frame_done,
    input  logic             bit_tick,
    output logic             expire_o
);
    localparam int TW = $clog2(TO_BITS + 1);

    logic [TW-1:0] idle_cnt;
    logic          rx_empty;
    logic          restart;

    assign rx_empty = (rx_level == '0);
    assign restart  = rx_pop | rx_frame_done;

    always_ff @(posedge clk) begin
        if (rst || rx_empty || restart)
            idle_cnt <= '0;
        else if (bit_tick && idle_cnt != TW'(TO_BITS))
            idle_cnt <= idle_cnt + 1'b1;
    end

    assign expire_o = !rx_empty && !restart && bit_tick && (idle_cnt == TW'(TO_BITS - 1));

    // R4
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst) rx_empty |=> (idle_cnt == '0));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) idle_cnt <= TW'(TO_BITS));
    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst) restart |=> (idle_cnt == '0));
endmodule

// File: rtl/ssp_irq_regs.sv
module ssp_irq_regs
    import ssp_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  irq_vec_t    raw_i,
    output irq_vec_t    clr_o,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    irq_vec_t mask_q;
    irq_vec_t masked;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (reg_wr && reg_addr == ADDR_MASK)
            mask_q <= irq_vec_t'(reg_wdata[NUM_SRC-1:0]);
    end

    assign masked = raw_i & mask_q;
    assign irq    = |masked;
    assign clr_o  = (reg_wr && reg_addr == ADDR_CLR) ? irq_vec_t'(reg_wdata[NUM_SRC-1:0]) : '0;

    always_comb begin
        case (reg_addr)
            ADDR_MASK:  reg_rdata = widen(mask_q);
            ADDR_RAW:   reg_rdata = widen(raw_i);
            ADDR_MSTAT: reg_rdata = widen(masked);
            default:    reg_rdata = '0;
        endcase
    end

    // R7
    no_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst) (mask_q == '0) |-> !irq);
    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != ADDR_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/ssp_irq_status.sv
module ssp_irq_status
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int TO_BITS = 32,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             rx_frame_done,
    input  logic             rx_pop,
    input  logic             bit_tick,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq
);
    irq_vec_t raw;
    irq_vec_t clr;
    logic     ovr_set;
    logic     idle_set;

    assign ovr_set = rx_frame_done && (rx_level == CNT_W'(DEPTH));

    ssp_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .rx_level      (rx_level),
        .tx_level      (tx_level),
        .rx_half_full  (raw.rx_half_full),
        .tx_half_empty (raw.tx_half_empty)
    );

    ssp_irq_timeout #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TO_BITS(TO_BITS)) u_timeout (
        .clk           (clk),
        .rst           (rst),
        .rx_level      (rx_level),
        .rx_pop        (rx_pop),
        .rx_frame_done (rx_frame_done),
        .bit_tick      (bit_tick),
        .expire_o      (idle_set)
    );

    ssp_irq_latch u_ovr_latch (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ovr_set),
        .clr_i  (clr.rx_overrun),
        .flag_o (raw.rx_overrun)
    );

    ssp_irq_latch u_idle_latch (
        .clk    (clk),
        .rst    (rst),
        .set_i  (idle_set),
        .clr_i  (clr.rx_idle),
        .flag_o (raw.rx_idle)
    );

    ssp_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw_i     (raw),
        .clr_o     (clr),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // R3
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(raw.rx_overrun) |-> $past(rx_frame_done && rx_level == CNT_W'(DEPTH)));
    // R4
    idle_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(raw.rx_idle) |-> $past(rx_level != '0));
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst) reg_rdata[31:NUM_SRC] == '0);
endmodule

// File: tb/ssp_irq_status_tb.sv
module ssp_irq_status_tb;
    localparam int DEPTH = 8;
    localparam int TO    = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 0;
    logic          rst = 1;
    logic [CW-1:0] rx_level = '0, tx_level = '0;
    logic          rx_frame_done = 0, rx_pop = 0, bit_tick = 0;
    logic          reg_wr = 0;
    logic [1:0]    reg_addr = 0;
    logic [31:0]   reg_wdata = 0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int    n_vec = 0, n_bad = 0, cyc = 0;
    int    m_ovr = 0, m_to = 0, m_cnt = 0, m_mask = 0;
    string phase = "R2";

    always #2.5 clk = ~clk;

    ssp_irq_status #(.DEPTH(DEPTH), .TO_BITS(TO)) u_dut (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .rx_frame_done(rx_frame_done), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic int exp_raw();
        int r;
        r = m_ovr | (m_to << 1);
        if (int'(rx_level) >= DEPTH / 2) r |= 4;
        if (int'(tx_level) <= DEPTH / 2) r |= 8;
        return r;
    endfunction

    task automatic compare();
        int raw, er;
        string tag;
        raw = exp_raw();
        case (reg_addr)
            2'd0: begin er = m_mask;       tag = "R8"; end
            2'd1: begin er = raw;          tag = "R1"; end
            2'd2: begin er = raw & m_mask; tag = "R7"; end
            default: begin er = 0;         tag = "R6"; end
        endcase
        n_vec++;
        if (reg_rdata !== 32'(er)) begin
            n_bad++;
            $display("FAIL %s [%s] rdata addr %0d got %h exp %h", tag, phase, reg_addr, reg_rdata, er);
        end
        n_vec++;
        if (irq !== ((raw & m_mask) != 0)) begin
            n_bad++;
            $display("FAIL R7 [%s] irq got %b exp %b", phase, irq, (raw & m_mask) != 0);
        end
    endtask

    task automatic model_edge();
        int clrv, set_o, exp_e;
        clrv  = (reg_wr && reg_addr == 2'd3) ? int'(reg_wdata) : 0;
        set_o = (rx_frame_done && int'(rx_level) == DEPTH) ? 1 : 0;
        exp_e = (rx_level != 0 && !rx_pop && !rx_frame_done && bit_tick && m_cnt == TO - 1) ? 1 : 0;
        if (set_o != 0) m_ovr = 1; else if ((clrv & 1) != 0) m_ovr = 0;
        if (exp_e != 0) m_to = 1;  else if ((clrv & 2) != 0) m_to = 0;
        if (rx_level == 0 || rx_pop || rx_frame_done) m_cnt = 0;
        else if (bit_tick && m_cnt < TO) m_cnt++;
        if (reg_wr && reg_addr == 2'd0) m_mask = int'(reg_wdata) & 15;
    endtask

    task automatic step(input int rxl, input int txl, input bit fd, input bit pop, input bit tk,
                        input bit wr, input int addr, input logic [31:0] wd);
        rx_level = CW'(rxl); tx_level = CW'(txl);
        rx_frame_done = fd; rx_pop = pop; bit_tick = tk;
        reg_wr = wr; reg_addr = 2'(addr); reg_wdata = wd;
        #1;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic read_all(input int rxl, input int txl);
        for (int a = 0; a < 4; a++) step(rxl, txl, 0, 0, 0, 0, a, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R2: reset state, empty FIFOs -> raw 0x8, mask 0, irq 0
        phase = "R2";
        read_all(0, 0);
        // R8: reserved mask bits ignored
        phase = "R8";
        step(0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFF0);
        read_all(0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
        read_all(0, 0);
        // R5: level sweep across threshold both ways
        phase = "R5";
        for (int l = 0; l <= DEPTH; l++) read_all(l, DEPTH - l);
        for (int l = DEPTH; l >= 0; l--) step(l, l, 0, 0, 0, 0, 1, 0);
        step(6, 2, 0, 0, 0, 1, 3, 32'hF);
        read_all(6, 2);
        // R3: frame done below full -> no overrun, at full -> overrun
        phase = "R3";
        step(7, 0, 1, 0, 0, 0, 1, 0);
        step(7, 0, 0, 0, 0, 0, 1, 0);
        step(DEPTH, 0, 1, 0, 0, 0, 1, 0);
        read_all(DEPTH, 0);
        // R6: clear overrun
        phase = "R6";
        step(DEPTH, 0, 0, 0, 0, 1, 3, 32'h1);
        read_all(DEPTH, 0);
        // R6: set and clear in the same cycle: set wins
        step(DEPTH, 0, 1, 0, 0, 1, 3, 32'h1);
        read_all(DEPTH, 0);
        step(DEPTH, 0, 0, 0, 0, 1, 3, 32'h1);
        // R9: writes to raw and masked addresses ignored
        phase = "R9";
        step(DEPTH, 0, 1, 0, 0, 0, 1, 0);
        step(DEPTH, 0, 0, 0, 0, 1, 1, 32'h0);
        step(DEPTH, 0, 0, 0, 0, 1, 2, 32'h0);
        read_all(DEPTH, 0);
        step(2, 0, 0, 0, 0, 1, 3, 32'h3);
        // R4: 31 ticks then pop, then 31 more: no timeout
        phase = "R4";
        for (int t = 0; t < TO - 1; t++) step(2, 0, 0, 0, 1, 0, 1, 0);
        step(2, 0, 0, 1, 0, 0, 1, 0);
        for (int t = 0; t < TO - 1; t++) step(2, 0, 0, 0, 1, 0, 1, 0);
        step(2, 0, 1, 0, 0, 0, 1, 0);
        // R4: full 32 ticks -> timeout, further ticks saturate
        for (int t = 0; t < TO; t++) step(1, 0, 0, 0, 1, 0, 2, 0);
        read_all(1, 0);
        step(1, 0, 0, 0, 0, 1, 3, 32'h2);
        for (int t = 0; t < 40; t++) step(1, 0, 0, 0, 1, 0, 1, 0);
        // R4: empty FIFO holds counter at zero
        for (int t = 0; t < 40; t++) step(0, 0, 0, 0, 1, 0, 1, 0);
        for (int t = 0; t < TO; t++) step(3, 0, 0, 0, t[0], 0, 1, 0);
        // R7: partial masks
        phase = "R7";
        for (int m = 0; m < 16; m++) begin
            step(DEPTH, DEPTH, 0, 0, 0, 1, 0, 32'(m));
            read_all(DEPTH, DEPTH);
            read_all(0, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule